// File: doc/BRIEF.md
# Majority-Clocked Triple LFSR Keystream Generator

This block produces a pseudo-random keystream, one bit per enabled cycle, from three Fibonacci shift registers of 19, 22 and 23 bits. The three registers do not all advance every cycle. Each register offers one clocking bit. A register advances only when its clocking bit agrees with the majority of the three, so at least two registers move on every step and the stepping pattern depends on the data. The output bit is the XOR of the top bit of each register.

A 64-bit key seeds the three registers in a single cycle on a load strobe. After loading, the block runs a fixed number of majority-clocked warm-up steps whose output is discarded. Only then does it raise its valid flag. An enable input gates all activity. While it is low, the registers and the warm-up count stay frozen and no bit is produced. A downstream consumer takes `ks_bit_o` in every cycle in which `ks_valid_o` is high.

Top module: `tri_lfsr_keystream`

## Requirements
- R1: A load copies key bits [18:0] into register A, bits [40:19] into register B and bits [63:41] into register C. Each register takes the lowest key bit of its slice at its bit 0.
- R2: A key slice that is all zero loads its register with the value 1, meaning only bit 0 is set. A non-zero slice loads unchanged.
- R3: A register that steps shifts toward its higher index. The new bit 0 is the XOR of these taps: bits 18, 4, 1 and 0 for A; bits 21 and 0 for B; bits 22, 14, 1 and 0 for C.
- R4: The clocking bits are A[8], B[10] and C[10]. On a step, a register advances exactly when its clocking bit equals the majority of the three, and the other registers hold.
- R5: `ks_bit_o` is A[18] XOR B[21] XOR C[22] of the present state. In every valid cycle the registers then take one majority step.
- R6: After a load, the first 100 enabled cycles are majority-clocked warm-up steps with `ks_valid_o` low. `ks_valid_o` is first high on the 101st enabled cycle.
- R7: While `en_i` is low and `load_i` is low, no register changes, the warm-up count holds and `ks_valid_o` is low.
- R8: After reset and before the first load, `ks_valid_o` stays low and the registers do not step, even with `en_i` high.
- R9: When `load_i` and `en_i` are high in the same cycle, the load wins. No bit is produced in that cycle, no step is taken, and the warm-up restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_i | input | 64 | Seed key, sampled when `load_i` is high |
| load_i | input | 1 | Load strobe: seeds the registers and restarts warm-up |
| en_i | input | 1 | Enable; when low, everything holds |
| ks_bit_o | output | 1 | Keystream bit, meaningful while `ks_valid_o` is high |
| ks_valid_o | output | 1 | High in each cycle that delivers a keystream bit |

## Verification
The two functions that can meet in one cycle are reloading and stepping. A load can arrive with `en_i` high, either in the middle of a warm-up or while bits are streaming. The bench provokes this by striking a new key in a cycle where streaming would otherwise take a step. It judges the outcome in two ways. First, valid must stay low in that cycle. Second, the bits after it must match an arithmetic model seeded fresh from the new key, with its full 100-step warm-up counted again. The bench also sweeps every single-bit key and several zero-slice keys under an irregular enable pattern, so that held cycles fall between warm-up and output steps.

// File: rtl/ks_pkg.sv
package ks_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_WARM = 2'd1,
      PH_RUN  = 2'd2
   } ks_phase_e;

   function automatic logic vote3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/ks_lfsr_stage.sv
module ks_lfsr_stage #(
   parameter int          LEN        = 19,
   parameter logic [LEN-1:0] TAPS    = '1,
   parameter int          CLK_POS    = 8,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic [LEN-1:0] seed_i,
   input  logic           step_i,
   output logic [LEN-1:0] state_o,
   output logic           clk_bit_o,
   output logic           last_bit_o
);

   localparam logic [LEN-1:0] ONE = LEN'(1);

   logic [LEN-1:0] q;
   logic [LEN-1:0] seed_fix;
   logic           fb;

   generate
      if (LEN < 2) begin : g_len_err
         $error("ks_lfsr_stage: LEN must be at least 2");
      end
      if (CLK_POS < 0 || CLK_POS >= LEN) begin : g_pos_err
         $error("ks_lfsr_stage: CLK_POS outside register");
      end
      if (TAPS[LEN-1] != 1'b1) begin : g_tap_err
         $error("ks_lfsr_stage: top tap must be set");
      end
      if (ZERO_GUARD) begin : g_guard
         assign seed_fix = (seed_i == '0) ? ONE : seed_i;
      end else begin : g_raw
         assign seed_fix = seed_i;
      end
   endgenerate

   assign fb = ^(q & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= ONE;
      end else if (load_i) begin
         q <= seed_fix;
      end else if (step_i) begin
         q <= {q[LEN-2:0], fb};
      end
   end

   assign state_o    = q;
   assign clk_bit_o  = q[CLK_POS];
   assign last_bit_o = q[LEN-1];

endmodule

// File: rtl/ks_majority.sv
module ks_majority #(
   parameter int N = 3
) (
   input  logic [N-1:0] clk_bits_i,
   output logic [N-1:0] sel_o
);

   logic maj;

   generate
      if (N != 3) begin : g_n_err
         $error("ks_majority: exactly three voters supported");
      end
   endgenerate

   assign maj = ks_pkg::vote3(clk_bits_i[0], clk_bits_i[1], clk_bits_i[2]);

   for (genvar i = 0; i < N; i++) begin : g_sel
      assign sel_o[i] = ~(clk_bits_i[i] ^ maj);
   end

endmodule

// File: rtl/ks_warmup_ctl.sv
module ks_warmup_ctl #(
   parameter int WARMUP = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic en_i,
   output logic advance_o,
   output logic valid_o
);

   import ks_pkg::*;

   localparam int CW = (WARMUP < 2) ? 1 : $clog2(WARMUP);
   localparam logic [CW-1:0] LAST = CW'(WARMUP - 1);

   ks_phase_e      phase;
   logic [CW-1:0]  cnt;

   generate
      if (WARMUP < 1) begin : g_wu_err
         $error("ks_warmup_ctl: WARMUP must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (load_i) begin
         phase <= PH_WARM;
         cnt   <= '0;
      end else if (en_i && phase == PH_WARM) begin
         if (cnt == LAST) begin
            phase <= PH_RUN;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign advance_o = en_i & ~load_i & (phase != PH_IDLE);
   assign valid_o   = en_i & ~load_i & (phase == PH_RUN);

endmodule

// File: rtl/tri_lfsr_keystream.sv
module tri_lfsr_keystream #(
   parameter int KEY_W  = 64,
   parameter int A_LEN  = 19,
   parameter int B_LEN  = 22,
   parameter int C_LEN  = 23,
   parameter logic [A_LEN-1:0] A_TAPS = 19'h40013,
   parameter logic [B_LEN-1:0] B_TAPS = 22'h200001,
   parameter logic [C_LEN-1:0] C_TAPS = 23'h404003,
   parameter int A_CLK  = 8,
   parameter int B_CLK  = 10,
   parameter int C_CLK  = 10,
   parameter int WARMUP = 100,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] key_i,
   input  logic             load_i,
   input  logic             en_i,
   output logic             ks_bit_o,
   output logic             ks_valid_o
);

   localparam int B_OFS = A_LEN;
   localparam int C_OFS = A_LEN + B_LEN;

   generate
      if (A_LEN + B_LEN + C_LEN != KEY_W) begin : g_key_err
         $error("tri_lfsr_keystream: register lengths must sum to KEY_W");
      end
   endgenerate

   logic [A_LEN-1:0] a_q;
   logic [B_LEN-1:0] b_q;
   logic [C_LEN-1:0] c_q;
   logic [2:0]       clk_bits;
   logic [2:0]       last_bits;
   logic [2:0]       sel;
   logic [2:0]       step;
   logic             advance;

   ks_warmup_ctl #(.WARMUP(WARMUP)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load_i),
      .en_i     (en_i),
      .advance_o(advance),
      .valid_o  (ks_valid_o)
   );

   ks_majority #(.N(3)) u_vote (
      .clk_bits_i(clk_bits),
      .sel_o     (sel)
   );

   assign step = {3{advance}} & sel;

   ks_lfsr_stage #(.LEN(A_LEN), .TAPS(A_TAPS), .CLK_POS(A_CLK), .ZERO_GUARD(ZERO_GUARD)) u_reg_a (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .seed_i    (key_i[A_LEN-1:0]),
      .step_i    (step[0]),
      .state_o   (a_q),
      .clk_bit_o (clk_bits[0]),
      .last_bit_o(last_bits[0])
   );

   ks_lfsr_stage #(.LEN(B_LEN), .TAPS(B_TAPS), .CLK_POS(B_CLK), .ZERO_GUARD(ZERO_GUARD)) u_reg_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .seed_i    (key_i[B_OFS +: B_LEN]),
      .step_i    (step[1]),
      .state_o   (b_q),
      .clk_bit_o (clk_bits[1]),
      .last_bit_o(last_bits[1])
   );

   ks_lfsr_stage #(.LEN(C_LEN), .TAPS(C_TAPS), .CLK_POS(C_CLK), .ZERO_GUARD(ZERO_GUARD)) u_reg_c (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load_i),
      .seed_i    (key_i[C_OFS +: C_LEN]),
      .step_i    (step[2]),
      .state_o   (c_q),
      .clk_bit_o (clk_bits[2]),
      .last_bit_o(last_bits[2])
   );

   assign ks_bit_o = ^last_bits;

endmodule

// File: rtl/ks_checker.sv
module ks_checker #(
   parameter int LA = 19,
   parameter int LB = 22,
   parameter int LC = 23
) (
   input logic          clk,
   input logic          rst_n,
   input logic          load_i,
   input logic          en_i,
   input logic          valid_o,
   input logic          advance,
   input logic [2:0]    sel,
   input logic [LA-1:0] a_q,
   input logic [LB-1:0] b_q,
   input logic [LC-1:0] c_q
);

   // R7
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !load_i) |=> ($stable(a_q) && $stable(b_q) && $stable(c_q)));

   // R4
   two_or_more_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> ($countones(sel) >= 2));

   // R4
   a_hold_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load_i && !sel[0]) |=> $stable(a_q));

   // R4
   b_hold_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load_i && !sel[1]) |=> $stable(b_q));

   // R4
   c_hold_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load_i && !sel[2]) |=> $stable(c_q));

   // R3
   a_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && sel[0]) |=> (a_q[LA-1:1] == $past(a_q[LA-2:0])));

   // R3
   c_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && sel[2]) |=> (c_q[LC-1:1] == $past(c_q[LC-2:0])));

   // R2
   nonzero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (a_q != '0 && b_q != '0 && c_q != '0));

   // R9
   load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !valid_o);

   // R5
   valid_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (en_i && !load_i && advance));

endmodule

bind tri_lfsr_keystream ks_checker #(.LA(A_LEN), .LB(B_LEN), .LC(C_LEN)) u_ks_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .load_i (load_i),
   .en_i   (en_i),
   .valid_o(ks_valid_o),
   .advance(advance),
   .sel    (sel),
   .a_q    (a_q),
   .b_q    (b_q),
   .c_q    (c_q)
);

// File: tb/tri_lfsr_keystream_bench.sv
`timescale 1ns/1ps
module tri_lfsr_keystream_bench;

   localparam real HALF = 2.5;
   localparam int  WU   = 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] key_i = '0;
   logic        load_i = 1'b0;
   logic        en_i = 1'b0;
   logic        ks_bit_o;
   logic        ks_valid_o;

   int total = 0;
   int bad   = 0;

   // bench model of the specification
   logic [18:0] m_a;
   logic [21:0] m_b;
   logic [22:0] m_c;
   int          m_phase = 0;   // 0 idle, 1 warm-up, 2 running
   int          m_cnt   = 0;

   always #(HALF) clk = ~clk;

   tri_lfsr_keystream u_tri_lfsr_keystream (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_i     (key_i),
      .load_i    (load_i),
      .en_i      (en_i),
      .ks_bit_o  (ks_bit_o),
      .ks_valid_o(ks_valid_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step();
      logic ca, cb, cc, mj;
      ca = m_a[8];
      cb = m_b[10];
      cc = m_c[10];
      mj = (ca & cb) | (ca & cc) | (cb & cc);
      if (ca == mj) m_a = {m_a[17:0], m_a[18] ^ m_a[4] ^ m_a[1] ^ m_a[0]};
      if (cb == mj) m_b = {m_b[20:0], m_b[21] ^ m_b[0]};
      if (cc == mj) m_c = {m_c[21:0], m_c[22] ^ m_c[14] ^ m_c[1] ^ m_c[0]};
   endtask

   // one cycle: drive enable, sample 1 ns after the falling edge, advance model
   task automatic cyc(input logic en, input string bit_tag);
      bit exp_v;
      logic exp_b;
      en_i = en;
      #1;
      exp_v = en && (m_phase == 2);
      if (m_phase == 0)
         check(ks_valid_o == 1'b0, "R8 valid before first load", 64'(ks_valid_o), 64'(exp_v));
      else if (!en)
         check(ks_valid_o == 1'b0, "R7 valid with enable low", 64'(ks_valid_o), 64'(exp_v));
      else if (m_phase == 1)
         check(ks_valid_o == 1'b0, "R6 valid during warm-up", 64'(ks_valid_o), 64'(exp_v));
      else
         check(ks_valid_o == 1'b1, "R6 valid after warm-up", 64'(ks_valid_o), 64'(exp_v));
      if (exp_v) begin
         exp_b = m_a[18] ^ m_b[21] ^ m_c[22];
         check(ks_bit_o == exp_b, bit_tag, 64'(ks_bit_o), 64'(exp_b));
      end
      if (en && m_phase != 0) begin
         model_step();
         if (m_phase == 1) begin
            m_cnt++;
            if (m_cnt == WU) m_phase = 2;
         end
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_load(input logic [63:0] k, input logic en);
      key_i  = k;
      load_i = 1'b1;
      en_i   = en;
      #1;
      check(ks_valid_o == 1'b0, "R9 no bit in load cycle", 64'(ks_valid_o), 64'h0);
      @(posedge clk);
      @(negedge clk);
      load_i = 1'b0;
      m_a = k[18:0];
      m_b = k[40:19];
      m_c = k[63:41];
      if (m_a == '0) m_a = 19'd1;
      if (m_b == '0) m_b = 22'd1;
      if (m_c == '0) m_c = 23'd1;
      m_phase = 1;
      m_cnt   = 0;
   endtask

   // load, warm up and stream under an irregular enable pattern
   task automatic run_key(input logic [63:0] k, input int nbits, input string tag);
      int produced;
      int i;
      do_load(k, 1'b0);
      produced = 0;
      i = 0;
      while (produced < nbits) begin
         logic en;
         en = ((i % 7) != 3) && ((i % 11) != 5);
         if (en && m_phase == 2) produced++;
         cyc(en, tag);
         i++;
      end
   endtask

   initial begin
      #(HALF * 2.0 * 200000.0);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_a = 19'd1;
      m_b = 22'd1;
      m_c = 23'd1;
      en_i = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      check(ks_valid_o == 1'b0, "R8 valid low in reset", 64'(ks_valid_o), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 6; i++) cyc(1'b1, "R8");

      // R1 R3 R4 R5: general keys
      run_key(64'h0123_4567_89AB_CDEF, 200, "R1 R3 R4 R5 stream key A");
      run_key(64'hFFFF_FFFF_FFFF_FFFF, 150, "R1 R3 R4 R5 stream all ones");
      run_key(64'hDEAD_BEEF_0BAD_F00D, 150, "R1 R3 R4 R5 stream key B");

      // R2: zero slices
      run_key(64'h0, 120, "R2 all-zero key");
      run_key(64'hFFFF_FE00_0007_FFFF, 120, "R2 middle slice zero");
      run_key(64'h0000_01FF_FFF8_0000, 120, "R2 outer slices zero");

      // R7: long enable-low stretch mid-stream, stream must resume unchanged
      run_key(64'h1357_9BDF_2468_ACE0, 40, "R5 before pause");
      for (int i = 0; i < 25; i++) cyc(1'b0, "R7");
      for (int i = 0; i < 60; i++) cyc(1'b1, "R7 resume after pause");

      // R9: load with enable high during streaming, then during warm-up
      do_load(64'h0F0F_F0F0_3C3C_C3C3, 1'b1);
      for (int i = 0; i < WU + 50; i++) cyc(1'b1, "R9 stream after load mid-run");
      for (int i = 0; i < 40; i++) cyc(1'b1, "R9 warm part");
      do_load(64'hA5A5_5A5A_9669_6996, 1'b1);
      for (int i = 0; i < 30; i++) cyc(1'b1, "R9 early");
      do_load(64'h7777_1111_2222_8888, 1'b1);
      for (int i = 0; i < WU + 60; i++) cyc(1'b1, "R9 stream after load mid-warm-up");

      // R1 sweep: every single-bit key
      for (int b = 0; b < 64; b++) begin
         run_key(64'd1 << b, 24, "R1 single-bit key sweep");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule